// File: doc/BRIEF.md
# Periodic DRAM Refresh Scheduler (Column-First Strobe Order)

This block keeps a dynamic memory refreshed without help from software. After reset it waits out the power-up settling time. It then owes the memory a burst of initialisation refresh cycles. From that point on, an interval timer adds one owed refresh every refresh slot, sized so that 2048 refreshes fit in every 32 ms. A saturating counter holds the number of owed refreshes. While that counter is non-zero the block raises its bus request towards the memory access controller.

When the request and the grant are both high in an idle cycle, the block drives one refresh cycle in which the column strobes fall before the row strobes. The memory then picks the row from its own internal counter, so no address is driven. Write enable stays high throughout, which keeps the memory out of its test mode. Each completed cycle retires one owed refresh. All strobe timings are given in nanoseconds and turned into whole clock cycles by rounding up.

Request and grant are a plain level handshake, not a data stream. Once a cycle has started it always runs to the end of precharge, even if grant drops partway through. A new cycle can start only from idle. The grant is therefore consulted only between cycles, and the access controller gets the bus back when busy falls.

Top module: `cbr_refresh_sched`

## Requirements
- R1: During and right after reset, every row strobe, every column strobe and write enable are high, and request and busy are low.
- R2: Request stays low for exactly POWERUP_NS/CLK_PERIOD_NS clock edges after reset is released. On the next edge it rises with INIT_CYCLES (default 8) refreshes owed. No periodic refresh is added before that point.
- R3: A cycle starts on the edge after the one where request and grant are both high in idle. The column strobes fall first. The row strobes follow ceil(10 ns / period) cycles later (at least 1 cycle). Busy is high from the column-strobe fall until the end of precharge.
- R4: The column strobes stay low for ceil(10 ns / period) cycles (at least 1) after the row strobes fall. They then return high while the row strobes are still low.
- R5: The row strobes stay low for ceil(60 ns / period) cycles. Precharge then lasts the largest of three values: ceil(40 ns / period), ceil(110 ns / period) minus the row-low time, and ceil(10 ns / period). During precharge both strobe groups are high, and the column strobes stay high until precharge ends. At 50 MHz this gives 1, 1, 3 and 3 cycles.
- R6: Write enable is high on every cycle, including the cycles before and after each row-strobe fall.
- R7: With grant low, no strobe ever goes low and busy stays low, whatever the number of owed refreshes.
- R8: Each completed cycle removes one owed refresh. Request falls on the edge that ends the precharge of the last owed cycle.
- R9: After the initialisation load, one refresh is added every REFRESH_PERIOD_NS/CLK_PERIOD_NS edges. The first is added that many edges after the load edge.
- R10: The owed count saturates at MAX_PENDING (default 8). When a long-withheld grant returns, exactly MAX_PENDING cycles run back to back, one idle cycle apart.
- R11: All NUM_RAS row-strobe bits always carry the same value, and all NUM_CAS column-strobe bits always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grant | input | 1 | Bus granted to the refresh block by the access controller |
| req | output | 1 | At least one refresh is owed |
| ras_n | output | NUM_RAS | Row strobes, active low |
| cas_n | output | NUM_CAS | Column strobes, active low |
| we_n | output | 1 | Write enable, active low, held high |
| busy | output | 1 | A refresh cycle owns the strobes |

## Verification
A wrong owed count shows up in the number of completed cycles. A count that is too high produces an extra cycle after the expected one. A count that is too low drops request early, within one cycle time of 7 clocks. A timer off by one moves the request edge by one clock, at power-up or at a slot boundary, and the bench samples that exact edge. A sequencer state that is wrong changes the measured column lead, hold, row-low or precharge length of the very cycle in which it happens. It is caught when busy falls.

// File: rtl/cbr_rfsh_pkg.sv
package cbr_rfsh_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_CSU  = 2'd1,
    SQ_ACT  = 2'd2,
    SQ_PRE  = 2'd3
  } seq_state_e;

  function automatic int ns_to_cyc(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int POWERUP_CYC  = 10000,
  parameter int INTERVAL_CYC = 780
) (
  input  logic clk,
  input  logic rst_n,
  output logic init_load,
  output logic tick
);
  localparam int TMAX = (POWERUP_CYC > INTERVAL_CYC) ? POWERUP_CYC : INTERVAL_CYC;
  localparam int W    = $clog2(TMAX + 1);
  localparam logic [W-1:0] PU_LAST = W'(POWERUP_CYC - 1);
  localparam logic [W-1:0] IV_LAST = W'(INTERVAL_CYC - 1);

  logic         running_q;
  logic [W-1:0] cnt_q;

  assign init_load = !running_q && (cnt_q == PU_LAST);
  assign tick      = running_q && (cnt_q == IV_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      cnt_q     <= '0;
    end else if (init_load || tick) begin
      running_q <= 1'b1;
      cnt_q     <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R9: consecutive ticks are never on neighbouring edges
  a_r9_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/rfsh_pending.sv
module rfsh_pending #(
  parameter int MAX_PEND  = 8,
  parameter int INIT_CNT  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  input  logic done,
  output logic nonzero
);
  localparam int CW = $clog2(MAX_PEND + 1);
  localparam logic [CW:0]   MAX_V  = (CW+1)'(MAX_PEND);
  localparam logic [CW-1:0] INIT_V = CW'((INIT_CNT < MAX_PEND) ? INIT_CNT : MAX_PEND);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   acc;

  always_comb begin
    acc = {1'b0, cnt_q} + {{CW{1'b0}}, tick};
    if (done && (acc != '0)) acc = acc - 1'b1;
    if (acc > MAX_V) acc = MAX_V;
    cnt_d = load ? INIT_V : acc[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign nonzero = (cnt_q != '0);

  // R10: the owed count never passes its ceiling
  a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= MAX_V[CW-1:0] || MAX_V[CW]);

  // R8: a completed cycle alone lowers the count by one
  a_r8_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !tick && !load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/rfsh_cbr_seq.sv
module rfsh_cbr_seq
  import cbr_rfsh_pkg::*;
#(
  parameter int T_CSR = 1,
  parameter int T_CHR = 1,
  parameter int T_RAS = 3,
  parameter int T_PRE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic ras_n,
  output logic cas_n,
  output logic busy,
  output logic done
);
  localparam int TMAX = max2(max2(T_CSR, T_CHR), max2(T_RAS, T_PRE));
  localparam int CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] CSU_LAST = CW'(T_CSR - 1);
  localparam logic [CW-1:0] ACT_LAST = CW'(T_RAS - 1);
  localparam logic [CW-1:0] PRE_LAST = CW'(T_PRE - 1);
  localparam logic [CW-1:0] CHR_N    = CW'(T_CHR);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ras_n_q, cas_n_q, busy_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    done    = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        cnt_d = '0;
        if (go) state_d = SQ_CSU;
      end
      SQ_CSU: if (cnt_q == CSU_LAST) begin
        state_d = SQ_ACT;
        cnt_d   = '0;
      end
      SQ_ACT: if (cnt_q == ACT_LAST) begin
        state_d = SQ_PRE;
        cnt_d   = '0;
      end
      SQ_PRE: if (cnt_q == PRE_LAST) begin
        state_d = SQ_IDLE;
        cnt_d   = '0;
        done    = 1'b1;
      end
      default: begin
        state_d = SQ_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      ras_n_q <= 1'b1;
      cas_n_q <= 1'b1;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ras_n_q <= (state_d != SQ_ACT);
      cas_n_q <= !((state_d == SQ_CSU) || ((state_d == SQ_ACT) && (cnt_d < CHR_N)));
      busy_q  <= (state_d != SQ_IDLE);
    end
  end

  assign ras_n = ras_n_q;
  assign cas_n = cas_n_q;
  assign busy  = busy_q;

  // checker: length of the current row-low stretch
  logic [CW:0] ras_lo_run;
  always_ff @(posedge clk) begin
    if (!rst_n || ras_n_q) ras_lo_run <= '0;
    else if (ras_lo_run != '1) ras_lo_run <= ras_lo_run + 1'b1;
  end

  // R3: column strobe already low on the cycle before the row strobe falls
  a_r3_cas_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_q) |-> (!cas_n_q && !$past(cas_n_q)));

  // R4: column strobe returns high only while the row strobe is still low
  a_r4_cas_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cas_n_q) && busy_q) |-> !ras_n_q);

  // R5: row strobe low for the full active time
  a_r5_ras_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n_q) |-> ras_lo_run >= (CW+1)'(T_RAS));

  // R5: column strobe never falls within one cycle of a row strobe rise
  a_r5_cas_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n_q) |-> (ras_n_q && $past(ras_n_q)));

endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched
  import cbr_rfsh_pkg::*;
#(
  parameter int CLK_PERIOD_NS     = 20,
  parameter int REFRESH_PERIOD_NS = 15600,
  parameter int POWERUP_NS        = 200000,
  parameter int CSR_NS            = 10,
  parameter int CHR_NS            = 10,
  parameter int RAS_NS            = 60,
  parameter int RP_NS             = 40,
  parameter int RC_NS             = 110,
  parameter int RPC_NS            = 10,
  parameter int INIT_CYCLES       = 8,
  parameter int MAX_PENDING       = 8,
  parameter int NUM_RAS           = 2,
  parameter int NUM_CAS           = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               grant,
  output logic               req,
  output logic [NUM_RAS-1:0] ras_n,
  output logic [NUM_CAS-1:0] cas_n,
  output logic               we_n,
  output logic               busy
);
  localparam int POWERUP_CYC  = POWERUP_NS / CLK_PERIOD_NS;
  localparam int INTERVAL_CYC = REFRESH_PERIOD_NS / CLK_PERIOD_NS;
  localparam int T_CSR = max2(1, ns_to_cyc(CSR_NS, CLK_PERIOD_NS));
  localparam int T_CHR = max2(1, ns_to_cyc(CHR_NS, CLK_PERIOD_NS));
  localparam int T_RAS = max2(1, ns_to_cyc(RAS_NS, CLK_PERIOD_NS));
  localparam int T_PRE = max2(max2(1, ns_to_cyc(RP_NS, CLK_PERIOD_NS)),
                              max2(ns_to_cyc(RC_NS, CLK_PERIOD_NS) - T_RAS,
                                   ns_to_cyc(RPC_NS, CLK_PERIOD_NS)));

  logic init_load, tick, done, go;
  logic ras_n_one, cas_n_one;

  rfsh_timer #(
    .POWERUP_CYC (POWERUP_CYC),
    .INTERVAL_CYC(INTERVAL_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_load(init_load),
    .tick     (tick)
  );

  rfsh_pending #(
    .MAX_PEND(MAX_PENDING),
    .INIT_CNT(INIT_CYCLES)
  ) u_pending (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (init_load),
    .tick   (tick),
    .done   (done),
    .nonzero(req)
  );

  assign go = req && grant;

  rfsh_cbr_seq #(
    .T_CSR(T_CSR),
    .T_CHR(T_CHR),
    .T_RAS(T_RAS),
    .T_PRE(T_PRE)
  ) u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (go),
    .ras_n(ras_n_one),
    .cas_n(cas_n_one),
    .busy (busy),
    .done (done)
  );

  for (genvar gr = 0; gr < NUM_RAS; gr++) begin : g_ras
    assign ras_n[gr] = ras_n_one;
  end
  for (genvar gc = 0; gc < NUM_CAS; gc++) begin : g_cas
    assign cas_n[gc] = cas_n_one;
  end

  assign we_n = 1'b1;

  // R7: a cycle begins only after request and grant were both high
  a_r7_start_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req && grant));

  // R6: write enable high around every row strobe fall
  a_r6_we_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n[0]) |-> (we_n && $past(we_n)));

  // R2: nothing is requested before the power-up wait has ended
  a_r2_quiet_boot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> ($past(init_load) || $past(tick)));

endmodule

// File: tb/cbr_refresh_sched_bench.sv
module cbr_refresh_sched_bench;
  localparam int NR = 2;
  localparam int NC = 4;
  localparam int P  = 40;   // power-up edges
  localparam int IV = 200;  // interval edges

  typedef struct packed {
    logic [7:0] lead;
    logic [7:0] hold;
    logic [7:0] rlow;
    logic [7:0] pre;
    logic       ok;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          grant = 1'b0;
  logic          req, we_n, busy;
  logic [NR-1:0] ras_n;
  logic [NC-1:0] cas_n;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int seen = 0;
  bit finished = 0;
  item_t exp_q[$];

  always #10 clk = ~clk;

  cbr_refresh_sched #(
    .CLK_PERIOD_NS    (20),
    .REFRESH_PERIOD_NS(IV * 20),
    .POWERUP_NS       (P * 20),
    .NUM_RAS          (NR),
    .NUM_CAS          (NC)
  ) u_cbr_refresh_sched (
    .clk  (clk),
    .rst_n(rst_n),
    .grant(grant),
    .req  (req),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .busy (busy)
  );

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(input bit good, input string tag, input int act, input int expv);
    compared++;
    if (!good) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, expv);
    end
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic push_items(input int n);
    for (int i = 0; i < n; i++) exp_q.push_back('{lead: 8'd1, hold: 8'd1, rlow: 8'd3, pre: 8'd3, ok: 1'b1});
  endtask

  task automatic summary();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // monitor: measure each refresh cycle at the ports and compare
  int    ph = 0;
  item_t cur;
  always @(negedge clk) begin
    if (rst_n) begin
      logic uni;
      uni = ((&ras_n) || !(|ras_n)) && ((&cas_n) || !(|cas_n));
      if (ph != 0) cur.ok = cur.ok && we_n && uni;
      case (ph)
        0: if (!cas_n[0] && ras_n[0]) begin
             ph = 1;
             cur = '{lead: 8'd1, hold: 8'd0, rlow: 8'd0, pre: 8'd0, ok: busy && we_n && uni};
           end
        1: if (!ras_n[0]) begin
             ph = 2; cur.rlow = 8'd1; cur.hold = {7'd0, !cas_n[0]};
           end else cur.lead++;
        2: if (ras_n[0]) begin
             ph = 3; cur.pre = 8'd1;
             cur.ok = cur.ok && cas_n[0];
           end else begin
             cur.rlow++;
             if (!cas_n[0]) cur.hold++;
           end
        default: if (!busy) begin
             item_t e;
             ph = 0; seen++;
             compared++;
             if (exp_q.size() == 0) begin
               mismatched++;
               $display("FAIL R8/R10 unexpected refresh cycle: actual %0d cycles expected %0d", seen, seen - 1);
             end else begin
               e = exp_q.pop_front();
               if (cur != e) begin
                 mismatched++;
                 $display("FAIL R3/R4/R5/R6/R11 shape: actual lead=%0d hold=%0d low=%0d pre=%0d ok=%0d expected lead=%0d hold=%0d low=%0d pre=%0d ok=%0d",
                          cur.lead, cur.hold, cur.rlow, cur.pre, cur.ok, e.lead, e.hold, e.rlow, e.pre, e.ok);
               end
             end
           end else begin
             cur.pre++;
             cur.ok = cur.ok && ras_n[0] && cas_n[0];
           end
      endcase
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(&ras_n && &cas_n && we_n && !req && !busy, "R1", {req, busy}, 0);
    rst_n = 1'b1;
    wait_cyc(P - 1);
    check(req == 1'b0, "R2 early", req, 0);
    wait_cyc(P);
    check(req == 1'b1, "R2 rise", req, 1);
    wait_cyc(P + 8);
    check(&cas_n && &ras_n && !busy, "R7 no grant", busy, 0);
    push_items(8);
    grant = 1'b1;
    wait_cyc(P + 90);
    check(req == 1'b0, "R8 drained", req, 0);
    check(seen == 8, "R2 init count", seen, 8);
    wait_cyc(P + IV - 1);
    check(req == 1'b0, "R9 before slot", req, 0);
    push_items(1);
    wait_cyc(P + IV);
    check(req == 1'b1, "R9 slot", req, 1);
    wait_cyc(P + IV + 1);
    check(!cas_n[0] && ras_n[0] && busy, "R3 start latency", cas_n[0], 0);
    wait_cyc(P + IV + 20);
    grant = 1'b0;
    wait_cyc(P + 5 * IV + 3);
    check(req && !busy && &cas_n, "R7 held off", busy, 0);
    wait_cyc(P + 10 * IV + 5);
    push_items(8);
    grant = 1'b1;
    wait_cyc(P + 10 * IV + 100);
    check(req == 1'b0, "R10 drained", req, 0);
    check(seen == 17, "R10 cycle count", seen, 17);
    check(exp_q.size() == 0, "R8 queue empty", exp_q.size(), 0);
    summary();
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

endmodule